// File: doc/BRIEF.md
# Cycle Counter with Compare Interrupts

This block keeps a free-running counter that advances by one on every clock. Three compare registers sit beside it. When the counter equals a compare value, that comparator's pending bit is set. Software reaches the counter, the compare values, the pending bits, a write-one-to-clear location and an enable mask through a small register port. Reads come straight from the registers; writes take effect at the next clock edge.

Each comparator has a fixed pending bit and a fixed priority level. The block raises a request only for sources that are enabled and whose level is strictly higher than the effective level. The effective level is the processor's current level. While the block is waiting for an interrupt, the level latched with the wait request is used instead. The request output gives the highest such level and a cause code.

An enabled pending source above the latched wait level ends the wait state and produces a one-cycle wake pulse.

Top module: `cci_timer_irq`

## Requirements
- R1: The counter increases by exactly one every cycle, wrapping modulo 2^32. Two reads of register address 0 on consecutive cycles differ by 1. A write to address 0 loads the counter, and the loaded value is seen one cycle later.
- R2: Comparators 0, 1 and 2 are written at addresses 1, 2 and 3. When the counter equals a compare value (full 32-bit equality, including after wraparound), pending bits 6, 10 and 13 are set respectively. A compare value written in the future leaves the pending register, read at address 4, at zero until the match.
- R3: A pending bit stays set until it is cleared. Writing ones to address 5 clears the matching pending bits, and address 5 reads as zero. Writing zeros to address 5 has no effect, and writes to address 4 are ignored.
- R4: Writing a compare register stores the value, which reads back at the same address. The same write clears that comparator's pending bit, and this takes precedence over a match in the same cycle.
- R5: The enable mask is read and written at address 6, using the same bit positions as the pending register. A request is raised only for a source that is both pending and enabled, and whose level is strictly above the effective level. Comparators 0, 1 and 2 have levels 1, 3 and 5.
- R6: The request output appears one cycle after the qualifying state and reports the highest qualifying level. The cause output is 4 for a level-1 request and 0 otherwise. When no request is raised, the level reads 0.
- R7: A match on a source that is not enabled still sets its pending bit but raises no request.
- R8: A wait request latches a wait level and asserts the waiting output on the next cycle. While waiting, the wait level replaces the current level. An enabled pending source above the wait level clears the waiting output and pulses wake for one cycle. A source at or below the wait level leaves the block waiting.
- R9: Reset clears the counter, the compare values, the pending bits, the enable mask, the request output and the waiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| cur_level | input | 3 | Current processor interrupt level |
| wait_req | input | 1 | Enter wait-for-interrupt state |
| wait_level | input | 3 | Level that applies during the wait |
| irq_valid | output | 1 | Interrupt request |
| irq_level | output | 3 | Level of the request |
| irq_cause | output | 6 | Cause code of the request |
| waiting | output | 1 | Block is in the wait state |
| wake | output | 1 | One-cycle pulse when the wait ends |

## Verification
The hardest situation to reach is a wait whose latched level differs from the current level while one source is pending below that wait level and another is still counting toward its match. The bench reads the counter and places two compare values 10 and 30 cycles ahead. It raises the current level to 7 and enters the wait at level 2. It then observes that the block stays waiting past the first match and wakes only on the second. Wraparound is reached by loading the counter just below 2^32 and setting a compare value of 2. A reference model compares every output on every cycle.

// File: rtl/cci_pkg.sv
package cci_pkg;
    localparam int NUM_SRC    = 3;
    localparam int ADDR_W     = 3;
    localparam int LVL1_CAUSE = 4;

    localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_PEND  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_EN    = 3'd6;

    // pending bit owned by each comparator
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 6;
            1:       return 10;
            default: return 13;
        endcase
    endfunction

    // priority level of each comparator
    function automatic int src_lvl(input int idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            default: return 5;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_addr(input int idx);
        return ADDR_W'(idx + 1);
    endfunction
endpackage

// File: rtl/cci_counter.sv
module cci_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = ld ? ld_val : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R1: free-running step of one
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> cnt_q == $past(cnt_q) + W'(1));

    // R1: load takes the written value
    p_cnt_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt_q == $past(ld_val));
endmodule

// File: rtl/cci_cmp_unit.sv
module cci_cmp_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cmp_val,
    output logic         match
);
    logic [W-1:0] cmp_d, cmp_q;

    always_comb begin
        cmp_d = wr ? wdata : cmp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign cmp_val = cmp_q;
    assign match   = (cnt == cmp_q);

    // R4: written compare value is retained
    p_cmp_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cmp_val == $past(wdata));
endmodule

// File: rtl/cci_lvl_pick.sv
module cci_lvl_pick
    import cci_pkg::*;
#(
    parameter int NUM   = 3,
    parameter int LVL_W = 3
) (
    input  logic [NUM-1:0]   active,
    input  logic [LVL_W-1:0] eff_lvl,
    output logic             hit,
    output logic [LVL_W-1:0] best_lvl
);
    always_comb begin
        best_lvl = '0;
        for (int i = 0; i < NUM; i++) begin
            if (active[i] && (LVL_W'(src_lvl(i)) > best_lvl)) begin
                best_lvl = LVL_W'(src_lvl(i));
            end
        end
        hit = best_lvl > eff_lvl;
    end
endmodule

// File: rtl/cci_timer_irq.sv
module cci_timer_irq
    import cci_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int LVL_W   = 3,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    input  logic [LVL_W-1:0]   cur_level,
    input  logic               wait_req,
    input  logic [LVL_W-1:0]   wait_level,
    output logic               irq_valid,
    output logic [LVL_W-1:0]   irq_level,
    output logic [CAUSE_W-1:0] irq_cause,
    output logic               waiting,
    output logic               wake
);
    localparam int PEND_W = CNT_W;

    typedef struct packed {
        logic [PEND_W-1:0]  pend;
        logic [PEND_W-1:0]  en;
        logic               waiting;
        logic [LVL_W-1:0]   wlvl;
        logic               wake;
        logic               irq_v;
        logic [LVL_W-1:0]   irq_l;
        logic [CAUSE_W-1:0] cause;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cmp_val [NUM_SRC];
    logic [NUM_SRC-1:0] match, cmp_wr, active;
    logic               cnt_ld, clr_wr, en_wr, hit;
    logic [LVL_W-1:0]   eff_lvl, best_lvl;

    assign cnt_ld = reg_wr && (reg_addr == ADR_COUNT);
    assign clr_wr = reg_wr && (reg_addr == ADR_CLR);
    assign en_wr  = reg_wr && (reg_addr == ADR_EN);

    cci_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cnt_ld),
        .ld_val (reg_wdata),
        .cnt    (cnt)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int SB = src_bit(i);

        assign cmp_wr[i] = reg_wr && (reg_addr == cmp_addr(i));

        cci_cmp_unit #(.W(CNT_W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (cmp_wr[i]),
            .wdata   (reg_wdata),
            .cnt     (cnt),
            .cmp_val (cmp_val[i]),
            .match   (match[i])
        );

        assign active[i] = st_q.pend[SB] & st_q.en[SB];

        // R2: an equality match lands in this source's pending bit
        p_match_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (match[i] && !cmp_wr[i]) |=> st_q.pend[SB]);

        // R4: rewriting the compare value drops the pending bit
        p_cmpwr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_wr[i] |=> !st_q.pend[SB]);
    end

    assign eff_lvl = st_q.waiting ? st_q.wlvl : cur_level;

    cci_lvl_pick #(.NUM(NUM_SRC), .LVL_W(LVL_W)) u_pick (
        .active   (active),
        .eff_lvl  (eff_lvl),
        .hit      (hit),
        .best_lvl (best_lvl)
    );

    always_comb begin
        st_d = st_q;
        // pending: clear first, then matches, then compare writes win
        if (clr_wr) st_d.pend = st_q.pend & ~reg_wdata;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (match[i]) st_d.pend[src_bit(i)] = 1'b1;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cmp_wr[i]) st_d.pend[src_bit(i)] = 1'b0;
        end
        if (en_wr) st_d.en = reg_wdata;
        // request
        st_d.irq_v = hit;
        st_d.irq_l = hit ? best_lvl : '0;
        st_d.cause = (hit && best_lvl == LVL_W'(1)) ? CAUSE_W'(LVL1_CAUSE) : '0;
        // wait handling
        st_d.wake = st_q.waiting && hit;
        if (st_q.waiting && hit) begin
            st_d.waiting = 1'b0;
        end else if (!st_q.waiting && wait_req) begin
            st_d.waiting = 1'b1;
            st_d.wlvl    = wait_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_COUNT: reg_rdata = cnt;
            ADR_PEND:  reg_rdata = st_q.pend;
            ADR_EN:    reg_rdata = st_q.en;
            default: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (reg_addr == cmp_addr(i)) reg_rdata = cmp_val[i];
                end
            end
        endcase
    end

    assign irq_valid = st_q.irq_v;
    assign irq_level = st_q.irq_l;
    assign irq_cause = st_q.cause;
    assign waiting   = st_q.waiting;
    assign wake      = st_q.wake;

    // R3: without a clear or compare write no pending bit falls
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && (cmp_wr == '0)) |=> (($past(st_q.pend) & ~st_q.pend) == '0));

    // R5: a request needs an enabled pending source above the effective level
    p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> !irq_valid);

    p_req_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (best_lvl <= eff_lvl) |=> !irq_valid);

    // R6: level-1 requests carry cause 4, idle output reads level 0
    p_cause_lvl1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_level == LVL_W'(1)) |-> irq_cause == CAUSE_W'(LVL1_CAUSE));

    p_idle_lvl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_level == '0 && irq_cause == '0));

    // R8: wake ends the wait and lasts one cycle
    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (!waiting && $past(waiting)));

    p_wake_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R6: only configured levels appear
    always @(posedge clk) begin
        if (rst_n) begin
            p_lvl_legal_r6: assert (irq_level == 3'd0 || irq_level == 3'd1 ||
                                    irq_level == 3'd3 || irq_level == 3'd5)
                else $error("illegal request level %0d", irq_level);
        end
    end
endmodule

// File: tb/cci_timer_irq_tb.sv
`timescale 1ns/1ps
module cci_timer_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [2:0]  cur_level = 3'd0;
    logic        wait_req = 1'b0;
    logic [2:0]  wait_level = 3'd0;
    logic        irq_valid;
    logic [2:0]  irq_level;
    logic [5:0]  irq_cause;
    logic        waiting;
    logic        wake;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wake_cnt = 0;

    always #2.5 clk = ~clk;

    cci_timer_irq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .cur_level(cur_level), .wait_req(wait_req),
        .wait_level(wait_level), .irq_valid(irq_valid), .irq_level(irq_level),
        .irq_cause(irq_cause), .waiting(waiting), .wake(wake)
    );

    // reference model
    int          SB [3] = '{6, 10, 13};
    int          SL [3] = '{1, 3, 5};
    logic [31:0] m_cnt, m_pend, m_en;
    logic [31:0] m_cmp [3];
    logic        m_wait, m_wake, m_iv, m_live = 1'b0;
    logic [2:0]  m_wlvl, m_il;
    logic [5:0]  m_cause;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pend = 0; m_en = 0;
            for (int i = 0; i < 3; i++) m_cmp[i] = 0;
            m_wait = 0; m_wlvl = 0; m_wake = 0; m_iv = 0; m_il = 0; m_cause = 0;
            m_live = 1'b1;
        end else begin
            int eff, best;
            bit hit;
            logic [31:0] np;
            eff = m_wait ? int'(m_wlvl) : int'(cur_level);
            best = 0;
            for (int i = 0; i < 3; i++)
                if (m_pend[SB[i]] && m_en[SB[i]] && SL[i] > best) best = SL[i];
            hit = best > eff;
            np = m_pend;
            if (wr && addr == 3'd5) np = np & ~wdata;
            for (int i = 0; i < 3; i++) if (m_cnt == m_cmp[i]) np[SB[i]] = 1'b1;
            for (int i = 0; i < 3; i++)
                if (wr && addr == 3'(i + 1)) begin np[SB[i]] = 1'b0; m_cmp[i] = wdata; end
            if (wr && addr == 3'd6) m_en = wdata;
            m_iv = hit;
            m_il = hit ? 3'(best) : 3'd0;
            m_cause = (hit && best == 1) ? 6'd4 : 6'd0;
            m_wake = m_wait && hit;
            if (m_wait && hit) m_wait = 0;
            else if (!m_wait && wait_req) begin m_wait = 1; m_wlvl = wait_level; end
            m_cnt = (wr && addr == 3'd0) ? wdata : m_cnt + 1;
            m_pend = np;
        end
    end

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt;
            3'd1: return m_cmp[0];
            3'd2: return m_cmp[1];
            3'd3: return m_cmp[2];
            3'd4: return m_pend;
            3'd6: return m_en;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R1 counter read";
            3'd1, 3'd2, 3'd3: return "R4 compare read";
            3'd4: return "R3 pending read";
            3'd6: return "R5 enable read";
            default: return "R3 clear/spare read";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (m_live) begin
            chk(rd_tag(addr), rdata, model_rd(addr));
            chk("R5 irq_valid", {31'd0, irq_valid}, {31'd0, m_iv});
            chk("R6 irq_level", {29'd0, irq_level}, {29'd0, m_il});
            chk("R6 irq_cause", {26'd0, irq_cause}, {26'd0, m_cause});
            chk("R8 waiting", {31'd0, waiting}, {31'd0, m_wait});
            chk("R8 wake", {31'd0, wake}, {31'd0, m_wake});
            if (wake === 1'b1) wake_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 50000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic enter_wait(input logic [2:0] l);
        @(posedge clk); #1;
        wait_req = 1'b1; wait_level = l;
        @(posedge clk); #1;
        wait_req = 1'b0;
    endtask

    initial begin
        logic [31:0] a, b, c;
        repeat (3) @(posedge clk);
        #1 addr = 3'd0;
        @(negedge clk);
        chk("R9 counter at reset", rdata, 32'd0);
        chk("R9 irq_valid at reset", {31'd0, irq_valid}, 32'd0);
        chk("R9 waiting at reset", {31'd0, waiting}, 32'd0);
        #1 addr = 3'd4;
        @(negedge clk);
        chk("R9 pending at reset", rdata, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1 consecutive reads
        reg_read(3'd0, a);
        reg_read(3'd0, b);
        chk("R1 consecutive reads differ by one", b - a, 32'd1);

        // quiet setup
        reg_write(3'd2, 32'h8000_0000);
        reg_write(3'd3, 32'h8000_0000);
        reg_write(3'd1, 32'h8000_0000);
        reg_write(3'd5, 32'hFFFF_FFFF);
        reg_write(3'd6, 32'd0);
        reg_read(3'd4, a);
        chk("R3 pending cleared", a, 32'd0);

        // R2 / R7: future compare, disabled source
        reg_read(3'd0, c);
        reg_write(3'd1, c + 20);
        reg_read(3'd4, a);
        chk("R2 future compare leaves pending zero", a, 32'd0);
        reg_read(3'd1, a);
        chk("R4 compare readback", a, c + 20);
        idle(25);
        reg_read(3'd4, a);
        chk("R2 comparator 0 sets bit 6", a, 32'h40);
        chk("R7 masked source raises no request", {31'd0, irq_valid}, 32'd0);

        // R3: ignored writes
        reg_write(3'd4, 32'd0);
        reg_read(3'd4, a);
        chk("R3 write to pending ignored", a, 32'h40);
        reg_write(3'd5, 32'd0);
        reg_read(3'd4, a);
        chk("R3 zero clear has no effect", a, 32'h40);
        reg_read(3'd5, a);
        chk("R3 clear reads zero", a, 32'd0);

        // R5 / R6: level 1 at current level 0
        cur_level = 3'd0;
        reg_write(3'd6, 32'h40);
        idle(2); @(negedge clk);
        chk("R5 level 1 taken at level 0", {31'd0, irq_valid}, 32'd1);
        chk("R6 level reported 1", {29'd0, irq_level}, 32'd1);
        chk("R6 cause 4 for level 1", {26'd0, irq_cause}, 32'd4);
        #1 cur_level = 3'd1;
        idle(2); @(negedge clk);
        chk("R5 level 1 blocked at level 1", {31'd0, irq_valid}, 32'd0);
        reg_write(3'd5, 32'h40);
        reg_read(3'd4, a);
        chk("R3 write-one clears bit 6", a, 32'd0);

        // level 3 at current level 2
        cur_level = 3'd2;
        reg_write(3'd6, 32'h440);
        reg_read(3'd0, c);
        reg_write(3'd2, c + 20);
        idle(25); @(negedge clk);
        chk("R5 level 3 taken at level 2", {31'd0, irq_valid}, 32'd1);
        chk("R6 level reported 3", {29'd0, irq_level}, 32'd3);
        chk("R6 cause 0 above level 1", {26'd0, irq_cause}, 32'd0);
        reg_read(3'd4, a);
        chk("R2 comparator 1 sets bit 10", a, 32'h400);
        #1 cur_level = 3'd3;
        idle(2); @(negedge clk);
        chk("R5 level 3 blocked at level 3", {31'd0, irq_valid}, 32'd0);

        // level 5 at current level 4
        #1 cur_level = 3'd4;
        reg_write(3'd6, 32'h2440);
        reg_read(3'd0, c);
        reg_write(3'd3, c + 20);
        idle(25); @(negedge clk);
        chk("R5 level 5 taken at level 4", {31'd0, irq_valid}, 32'd1);
        chk("R6 level reported 5", {29'd0, irq_level}, 32'd5);
        #1 cur_level = 3'd5;
        idle(2); @(negedge clk);
        chk("R5 level 5 blocked at level 5", {31'd0, irq_valid}, 32'd0);

        // highest level wins, compare write clears
        #1 cur_level = 3'd0;
        idle(2); @(negedge clk);
        chk("R6 highest of levels 3 and 5", {29'd0, irq_level}, 32'd5);
        reg_write(3'd3, 32'h8000_0000);
        reg_read(3'd4, a);
        chk("R4 compare write clears bit 13", a, 32'h400);
        idle(1); @(negedge clk);
        chk("R6 falls back to level 3", {29'd0, irq_level}, 32'd3);
        reg_write(3'd2, 32'h8000_0000);
        reg_read(3'd4, a);
        chk("R4 compare write clears bit 10", a, 32'd0);

        // R7: masked earlier match, enabled later match
        reg_write(3'd6, 32'h40);
        reg_read(3'd0, c);
        reg_write(3'd2, c + 20);
        reg_write(3'd1, c + 40);
        idle(28);
        reg_read(3'd4, a);
        chk("R7 masked match sets bit 10", a, 32'h400);
        chk("R7 masked match no request", {31'd0, irq_valid}, 32'd0);
        idle(15); @(negedge clk);
        chk("R7 enabled later match requests", {31'd0, irq_valid}, 32'd1);
        chk("R7 request is level 1", {29'd0, irq_level}, 32'd1);

        // R8: wait at level 0 while current level is 7
        #1 cur_level = 3'd7;
        reg_write(3'd5, 32'hFFFF_FFFF);
        reg_read(3'd0, c);
        reg_write(3'd1, c + 20);
        enter_wait(3'd0);
        @(negedge clk);
        chk("R8 waiting after wait request", {31'd0, waiting}, 32'd1);
        idle(25); @(negedge clk);
        chk("R8 wait ended by level 1", {31'd0, waiting}, 32'd0);
        chk("R8 one wake pulse", wake_cnt, 32'd1);

        // R8: wait level 2 ignores level 1, wakes on level 3
        reg_write(3'd5, 32'hFFFF_FFFF);
        reg_write(3'd6, 32'h440);
        reg_read(3'd0, c);
        reg_write(3'd1, c + 10);
        reg_write(3'd2, c + 30);
        enter_wait(3'd2);
        idle(18); @(negedge clk);
        chk("R8 level 1 does not end wait at 2", {31'd0, waiting}, 32'd1);
        reg_read(3'd4, a);
        chk("R8 level 1 pending during wait", a, 32'h40);
        idle(20); @(negedge clk);
        chk("R8 level 3 ends wait at 2", {31'd0, waiting}, 32'd0);
        chk("R8 second wake pulse", wake_cnt, 32'd2);
        #1 cur_level = 3'd0;

        // R2 / R1: wraparound match
        reg_write(3'd6, 32'd0);
        reg_write(3'd0, 32'hFFFF_FFF0);
        reg_read(3'd0, a);
        chk("R1 counter load", a, 32'hFFFF_FFF1);
        reg_write(3'd1, 32'h0000_0002);
        reg_write(3'd5, 32'hFFFF_FFFF);
        reg_read(3'd4, a);
        chk("R2 no match before wrap", a & 32'h40, 32'd0);
        idle(25);
        reg_read(3'd4, a);
        chk("R2 match after wrap", a & 32'h40, 32'h40);

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule